// File: doc/BRIEF.md
# Dual-Mode Host Bus Slave Interface

This block sits between a host processor bus and an internal 1024-word by 16-bit RAM plus a 64-entry by 16-bit register file. Pin straps choose the host signalling. One choice uses separate active-low read and write strobes. The other uses a data strobe of selectable polarity together with a read/write line. A width strap chooses an 8-bit or a 16-bit data path, and a byte-order strap chooses which byte an 8-bit host reaches at an even address.

The address can come straight from the address pins. It can also arrive on the data lines of a multiplexed bus, where two enables capture it: one for the low half and one for the high half. The effective address is always shown on an output.

A second, internal port shares the RAM. When a host RAM access and the internal port target the same word in the same cycle, the block drives busy. The internal port then wins and any host write waits.

Top module: `host_bus_if`

## Requirements
- R1: With `proto_sel_i`=0, `strb_a_i` low is a read and `strb_b_i` low is a write.
- R2: With `proto_sel_i`=1, `strb_a_i` is a data strobe that is active low when `strobe_pol_i`=0 and active high when it is 1. While the strobe is active, `strb_b_i`=1 reads and 0 writes. With the strobe inactive, nothing is written.
- R3: A RAM access needs `ram_cs_n_i`=2'b00. A register access needs `reg_cs_n_i`=0 and `reg_cs_i`=1, and the RAM wins if both are selected. With neither selected, a write changes nothing and `dat_o` is zero.
- R4: With `wide_i`=0, data moves on bits 7..0 and `dat_o[15:8]` is zero. The byte reached is the high byte when (address bit 0 XOR `byte_hi_first_i`) is 1, and the low byte otherwise.
- R5: With `wide_i`=1, the low byte lane is enabled when address bit 0 is 0 and the high lane when `bhe_ni` is 0. A disabled lane reads as zero.
- R6: A write updates only the enabled byte lanes. The other byte of the word is kept.
- R7: Address bits 10..1 select the RAM word and bits 6..1 select the register. Higher bits are ignored for registers, and all registers reset to zero.
- R8: With `mux_en_i`=1, `ale_lo_i`/`ale_hi_i` at 1 pass `dat_i[7:0]`/`dat_i[15:8]` into the address, and when they are 0 the last value is held. `addr_o` always shows the effective address, which equals `addr_i` when `mux_en_i`=0.
- R9: `busy_no` is low, in the same cycle, exactly when a RAM read or write strobe is active, `int_en_i` is 1 and `int_addr_i` equals the host word address.
- R10: On a collision, an internal write takes effect and the host write does not. A held host write completes at the first clock edge at which busy is released.
- R11: While a read is active on a selected target, `dat_o` shows the steered data without a clock delay. Otherwise `dat_o` is zero.
- R12: `int_en_i`=1 with `int_we_i`=1 writes the full word at the clock edge. `int_rdat_o` shows the word at `int_addr_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| proto_sel_i | input | 1 | 0 separate strobes, 1 data strobe plus read/write |
| strobe_pol_i | input | 1 | Data strobe polarity, 1 active high |
| wide_i | input | 1 | 0 8-bit, 1 16-bit data path |
| byte_hi_first_i | input | 1 | Byte order for 8-bit access |
| mux_en_i | input | 1 | Address taken from data lines via latches |
| ale_lo_i | input | 1 | Low address latch enable |
| ale_hi_i | input | 1 | High address latch enable |
| addr_i | input | 16 | Direct address |
| addr_o | output | 16 | Effective address |
| dat_i | input | 16 | Host write data / multiplexed address |
| dat_o | output | 16 | Host read data |
| strb_a_i | input | 1 | Read strobe or data strobe |
| strb_b_i | input | 1 | Write strobe or read/write |
| bhe_ni | input | 1 | High byte enable, active low |
| ram_cs_n_i | input | 2 | RAM selects, both active low |
| reg_cs_n_i | input | 1 | Register select, active low |
| reg_cs_i | input | 1 | Register select, active high |
| busy_no | output | 1 | Same-word collision, active low |
| int_en_i | input | 1 | Internal port access |
| int_we_i | input | 1 | Internal port write |
| int_addr_i | input | 10 | Internal port word address |
| int_wdat_i | input | 16 | Internal port write data |
| int_rdat_o | output | 16 | Internal port read data |

## Verification
The assertions check on every cycle several properties that hold regardless of the data pattern. Busy only appears with an active internal port aimed at the shown word address. A direct address is passed through when multiplexing is off, and a transparent latch follows the data lines. An idle latch keeps its value. The upper read byte stays zero in 8-bit mode, and an internal write is visible one cycle later at an unchanged address. Lane steering under both byte orders and both polarities of the data strobe can only be shown by the bench's scenarios. The same is true of chip-select rejection, register aliasing and a stalled host write completing after the collision clears.

// File: rtl/host_bus_pkg.sv
package host_bus_pkg;
  typedef enum logic {PROTO_SPLIT = 1'b0, PROTO_DSTRB = 1'b1} proto_e;
  typedef struct packed {
    logic rd;
    logic wr;
  } acc_t;
endpackage

// File: rtl/host_bus_strobe.sv
module host_bus_strobe
  import host_bus_pkg::*;
(
  input  logic proto_i,
  input  logic pol_i,
  input  logic strb_a_i,
  input  logic strb_b_i,
  output acc_t acc_o
);
  logic ds_on;

  always_comb begin
    ds_on = pol_i ? strb_a_i : ~strb_a_i;
    if (proto_e'(proto_i) == PROTO_DSTRB) begin
      acc_o.rd = ds_on & strb_b_i;
      acc_o.wr = ds_on & ~strb_b_i;
    end else begin
      acc_o.rd = ~strb_a_i;
      acc_o.wr = ~strb_b_i;
    end
  end
endmodule

// File: rtl/host_bus_addr_latch.sv
module host_bus_addr_latch #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mux_en_i,
  input  logic          ale_lo_i,
  input  logic          ale_hi_i,
  input  logic [AW-1:0] dat_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  localparam int HALF = AW / 2;

  logic [1:0]    ale;
  logic [AW-1:0] muxed;

  assign ale = {ale_hi_i, ale_lo_i};

  for (genvar g = 0; g < 2; g++) begin : g_half
    logic [HALF-1:0] held_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     held_q <= '0;
      else if (ale[g]) held_q <= dat_i[g*HALF +: HALF];
    end
    // transparent while enable is high
    assign muxed[g*HALF +: HALF] = ale[g] ? dat_i[g*HALF +: HALF] : held_q;
  end

  assign addr_o = mux_en_i ? muxed : addr_i;
endmodule

// File: rtl/host_bus_lanes.sv
module host_bus_lanes #(
  parameter int DW = 16
) (
  input  logic          wide_i,
  input  logic          hi_first_i,
  input  logic          a0_i,
  input  logic          bhe_ni,
  input  logic [DW-1:0] wdat_i,
  input  logic [DW-1:0] rword_i,
  output logic [1:0]    be_o,
  output logic [DW-1:0] wword_o,
  output logic [DW-1:0] rdat_o
);
  localparam int BW = DW / 2;

  logic sel_hi;

  always_comb begin
    sel_hi  = a0_i ^ hi_first_i;
    be_o    = '0;
    wword_o = wdat_i;
    rdat_o  = '0;
    if (!wide_i) begin
      be_o             = sel_hi ? 2'b10 : 2'b01;
      wword_o          = {wdat_i[BW-1:0], wdat_i[BW-1:0]};
      rdat_o[BW-1:0]   = sel_hi ? rword_i[DW-1:BW] : rword_i[BW-1:0];
    end else begin
      be_o = {~bhe_ni, ~a0_i};
      for (int g = 0; g < 2; g++) begin
        if (be_o[g]) rdat_o[g*BW +: BW] = rword_i[g*BW +: BW];
      end
    end
  end
endmodule

// File: rtl/host_bus_if.sv
module host_bus_if
  import host_bus_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int RAM_AW = 10,
  parameter int REG_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              proto_sel_i,
  input  logic              strobe_pol_i,
  input  logic              wide_i,
  input  logic              byte_hi_first_i,
  input  logic              mux_en_i,
  input  logic              ale_lo_i,
  input  logic              ale_hi_i,
  input  logic [AW-1:0]     addr_i,
  output logic [AW-1:0]     addr_o,
  input  logic [DW-1:0]     dat_i,
  output logic [DW-1:0]     dat_o,
  input  logic              strb_a_i,
  input  logic              strb_b_i,
  input  logic              bhe_ni,
  input  logic [1:0]        ram_cs_n_i,
  input  logic              reg_cs_n_i,
  input  logic              reg_cs_i,
  output logic              busy_no,
  input  logic              int_en_i,
  input  logic              int_we_i,
  input  logic [RAM_AW-1:0] int_addr_i,
  input  logic [DW-1:0]     int_wdat_i,
  output logic [DW-1:0]     int_rdat_o
);
  localparam int RAM_DEPTH = 1 << RAM_AW;
  localparam int REG_DEPTH = 1 << REG_AW;
  localparam int BW        = DW / 2;

  acc_t              acc;
  logic [AW-1:0]     eff_addr;
  logic              ram_sel, reg_sel, collide, ram_we, reg_we;
  logic [RAM_AW-1:0] ram_idx;
  logic [REG_AW-1:0] reg_idx;
  logic [DW-1:0]     rword, wword, rdat;
  logic [1:0]        be;

  logic [DW-1:0] ram_q [RAM_DEPTH];
  logic [DW-1:0] reg_q [REG_DEPTH];

  host_bus_strobe u_strobe (
    .proto_i  (proto_sel_i),
    .pol_i    (strobe_pol_i),
    .strb_a_i (strb_a_i),
    .strb_b_i (strb_b_i),
    .acc_o    (acc)
  );

  host_bus_addr_latch #(.AW(AW)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mux_en_i (mux_en_i),
    .ale_lo_i (ale_lo_i),
    .ale_hi_i (ale_hi_i),
    .dat_i    (dat_i),
    .addr_i   (addr_i),
    .addr_o   (eff_addr)
  );

  assign addr_o  = eff_addr;
  assign ram_idx = eff_addr[RAM_AW:1];
  assign reg_idx = eff_addr[REG_AW:1];
  assign ram_sel = (ram_cs_n_i == 2'b00);
  assign reg_sel = ~ram_sel & ~reg_cs_n_i & reg_cs_i;

  // internal port wins on same-word overlap
  assign collide = ram_sel & (acc.rd | acc.wr) & int_en_i & (int_addr_i == ram_idx);
  assign busy_no = ~collide;

  assign rword = ram_sel ? ram_q[ram_idx] : reg_q[reg_idx];

  host_bus_lanes #(.DW(DW)) u_lanes (
    .wide_i     (wide_i),
    .hi_first_i (byte_hi_first_i),
    .a0_i       (eff_addr[0]),
    .bhe_ni     (bhe_ni),
    .wdat_i     (dat_i),
    .rword_i    (rword),
    .be_o       (be),
    .wword_o    (wword),
    .rdat_o     (rdat)
  );

  assign dat_o  = (acc.rd & (ram_sel | reg_sel)) ? rdat : '0;
  assign ram_we = acc.wr & ram_sel & ~collide;
  assign reg_we = acc.wr & reg_sel;

  assign int_rdat_o = ram_q[int_addr_i];

  always_ff @(posedge clk_i) begin
    if (int_en_i && int_we_i) ram_q[int_addr_i] <= int_wdat_i;
    for (int g = 0; g < 2; g++) begin
      if (ram_we && be[g]) ram_q[ram_idx][g*BW +: BW] <= wword[g*BW +: BW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < REG_DEPTH; r++) reg_q[r] <= '0;
    end else begin
      for (int g = 0; g < 2; g++) begin
        if (reg_we && be[g]) reg_q[reg_idx][g*BW +: BW] <= wword[g*BW +: BW];
      end
    end
  end
endmodule

// File: rtl/host_bus_if_chk.sv
module host_bus_if_chk #(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int RAM_AW = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mux_en_i,
  input logic              ale_lo_i,
  input logic              ale_hi_i,
  input logic              wide_i,
  input logic [AW-1:0]     addr_i,
  input logic [AW-1:0]     addr_o,
  input logic [DW-1:0]     dat_i,
  input logic [DW-1:0]     dat_o,
  input logic              busy_no,
  input logic              int_en_i,
  input logic              int_we_i,
  input logic [RAM_AW-1:0] int_addr_i,
  input logic [DW-1:0]     int_wdat_i,
  input logic [DW-1:0]     int_rdat_o
);
  localparam int AH = AW / 2;
  localparam int DH = DW / 2;

  a_r9_busy_needs_int: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_no |-> int_en_i);

  a_r9_busy_same_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_no |-> (int_addr_i == addr_o[RAM_AW:1]));

  a_r8_direct_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mux_en_i |-> (addr_o == addr_i));

  a_r8_lo_transparent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_en_i && ale_lo_i) |-> (addr_o[AH-1:0] == dat_i[AH-1:0]));

  a_r8_hi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_en_i && !ale_hi_i) ##1 (mux_en_i && !ale_hi_i) |-> $stable(addr_o[AW-1:AH]));

  a_r4_narrow_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_i |-> (dat_o[DW-1:DH] == '0));

  a_r10_int_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_en_i && int_we_i) ##1 (int_addr_i == $past(int_addr_i))
      |-> (int_rdat_o == $past(int_wdat_i)));
endmodule

bind host_bus_if host_bus_if_chk #(.AW(AW), .DW(DW), .RAM_AW(RAM_AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mux_en_i   (mux_en_i),
  .ale_lo_i   (ale_lo_i),
  .ale_hi_i   (ale_hi_i),
  .wide_i     (wide_i),
  .addr_i     (addr_i),
  .addr_o     (addr_o),
  .dat_i      (dat_i),
  .dat_o      (dat_o),
  .busy_no    (busy_no),
  .int_en_i   (int_en_i),
  .int_we_i   (int_we_i),
  .int_addr_i (int_addr_i),
  .int_wdat_i (int_wdat_i),
  .int_rdat_o (int_rdat_o)
);

// File: tb/host_bus_if_bench.sv
module host_bus_if_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        proto = 0, pol = 0, wide = 1, bytehi = 0, mux = 0, ale_lo = 0, ale_hi = 0;
  logic [15:0] a = '0, d = '0;
  logic        sa = 1, sb = 1, bhe_n = 1;
  logic [1:0]  cs_n = 2'b11;
  logic        pcs_n = 1, pcs = 0;
  logic        int_en = 0, int_we = 0;
  logic [9:0]  int_addr = '0;
  logic [15:0] int_wdat = '0;
  logic [15:0] addr_o, dat_o, int_rdat;
  logic        busy_n;

  host_bus_if u_host_bus_if (
    .clk_i(clk), .rst_ni(rst_n), .proto_sel_i(proto), .strobe_pol_i(pol),
    .wide_i(wide), .byte_hi_first_i(bytehi), .mux_en_i(mux),
    .ale_lo_i(ale_lo), .ale_hi_i(ale_hi), .addr_i(a), .addr_o(addr_o),
    .dat_i(d), .dat_o(dat_o), .strb_a_i(sa), .strb_b_i(sb), .bhe_ni(bhe_n),
    .ram_cs_n_i(cs_n), .reg_cs_n_i(pcs_n), .reg_cs_i(pcs), .busy_no(busy_n),
    .int_en_i(int_en), .int_we_i(int_we), .int_addr_i(int_addr),
    .int_wdat_i(int_wdat), .int_rdat_o(int_rdat)
  );

  int errs = 0, checks = 0;
  logic [15:0] m_ram [0:1023];
  logic [15:0] m_reg [0:63];
  logic [7:0]  m_lo = '0, m_hi = '0;

  // expected values for the current cycle
  logic [15:0] e_addr, e_dout, merged;
  logic        e_busy, is_rd, is_wr, to_ram, to_reg;
  logic [9:0]  word;
  logic [5:0]  rix;

  task automatic cmp(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_eval();
    logic ds_on, hi, lo_on, hi_on;
    logic [15:0] cur;
    e_addr = a;
    if (mux) begin
      e_addr[7:0]  = ale_lo ? d[7:0]  : m_lo;
      e_addr[15:8] = ale_hi ? d[15:8] : m_hi;
    end
    if (proto) begin
      ds_on = pol ? sa : !sa;
      is_rd = ds_on && sb;
      is_wr = ds_on && !sb;
    end else begin
      is_rd = !sa;
      is_wr = !sb;
    end
    to_ram = (cs_n == 2'b00);
    to_reg = !to_ram && !pcs_n && pcs;
    word   = e_addr[10:1];
    rix    = e_addr[6:1];
    e_busy = !(to_ram && (is_rd || is_wr) && int_en && int_addr == word);
    cur    = to_ram ? m_ram[word] : m_reg[rix];
    hi     = e_addr[0] != bytehi;
    if (!wide) begin
      lo_on = !hi;
      hi_on = hi;
    end else begin
      lo_on = !e_addr[0];
      hi_on = !bhe_n;
    end
    e_dout = '0;
    if (is_rd && (to_ram || to_reg)) begin
      if (!wide) e_dout = {8'h00, hi ? cur[15:8] : cur[7:0]};
      else       e_dout = {hi_on ? cur[15:8] : 8'h00, lo_on ? cur[7:0] : 8'h00};
    end
    merged = cur;
    if (lo_on) merged[7:0]  = d[7:0];
    if (hi_on) merged[15:8] = wide ? d[15:8] : d[7:0];
  endtask

  task automatic tick(string tag);
    #4;
    model_eval();
    cmp(tag, "addr_o", addr_o, e_addr);
    cmp(tag, "dat_o", dat_o, e_dout);
    cmp(tag, "busy_no", {15'd0, busy_n}, {15'd0, e_busy});
    cmp(tag, "int_rdat_o", int_rdat, m_ram[int_addr]);
    @(posedge clk);
    if (rst_n) begin
      if (int_en && int_we) m_ram[int_addr] = int_wdat;
      if (is_wr && to_ram && e_busy) m_ram[word] = merged;
      if (is_wr && to_reg) m_reg[rix] = merged;
      if (ale_lo) m_lo = d[7:0];
      if (ale_hi) m_hi = d[15:8];
    end
    #1;
  endtask

  initial begin
    #2000000;
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m_reg[i] = '0;
    for (int i = 0; i < 1024; i++) m_ram[i] = '0;
    @(posedge clk); #1;
    // reset state: R11 idle read data, R7 registers cleared
    tick("R11");
    rst_n = 1'b1;
    cs_n = 2'b11; pcs_n = 0; pcs = 1; sa = 0; a = 16'h0006;
    tick("R7");
    sa = 1; pcs_n = 1; pcs = 0;

    // R12 fill RAM through the internal port
    int_en = 1; int_we = 1;
    for (int i = 0; i < 1024; i++) begin
      int_addr = 10'(i);
      int_wdat = 16'(i * 257) ^ 16'h5a3c;
      tick("R12");
    end
    int_en = 0; int_we = 0;

    // R1 split strobes, 16-bit
    wide = 1; cs_n = 2'b00; bhe_n = 0; a = 16'h0010; d = 16'hbeef;
    sb = 0; tick("R1");
    sb = 1; sa = 0; tick("R1");
    sa = 1; tick("R11");

    // R6 / R5 lane writes and reads
    bhe_n = 1; d = 16'h1234; sb = 0; tick("R6");
    sb = 1; bhe_n = 0; sa = 0; tick("R6");
    a = 16'h0011; tick("R5");
    sa = 1; d = 16'haa55; sb = 0; tick("R6");
    sb = 1; a = 16'h0010; sa = 0; tick("R5");
    sa = 1;

    // R4 8-bit, both byte orders
    wide = 0; bytehi = 0; a = 16'h0021; d = 16'h00c3; sb = 0; tick("R4");
    sb = 1; sa = 0; tick("R4");
    a = 16'h0020; tick("R4");
    bytehi = 1; tick("R4");
    sa = 1; a = 16'h0021; d = 16'h007e; sb = 0; tick("R4");
    sb = 1; sa = 0; tick("R4");
    a = 16'h0020; tick("R4");
    sa = 1; bytehi = 0; wide = 1;

    // R2 data strobe plus read/write, both polarities
    proto = 1; pol = 0; a = 16'h0030; d = 16'hc001;
    sa = 1; sb = 0; tick("R2");
    sa = 0; tick("R2");
    sa = 1; sb = 1; tick("R2");
    sa = 0; tick("R2");
    pol = 1; sa = 0; sb = 0; d = 16'h0ff0; a = 16'h0032; tick("R2");
    sa = 1; tick("R2");
    sb = 1; tick("R2");
    sa = 0; proto = 0; sa = 1; sb = 1; pol = 0;

    // R3 selects
    cs_n = 2'b01; a = 16'h0040; d = 16'hdead; sb = 0; tick("R3");
    sb = 1; cs_n = 2'b00; sa = 0; tick("R3");
    sa = 1; cs_n = 2'b11; pcs_n = 0; pcs = 1; a = 16'h0006; d = 16'h4321; sb = 0; tick("R3");
    sb = 1; sa = 0; tick("R3");
    a = 16'h0086; tick("R7");
    pcs = 0; tick("R3");
    pcs = 1; cs_n = 2'b00; tick("R3");
    sa = 1; pcs_n = 1; pcs = 0;

    // R8 multiplexed address
    mux = 1; ale_lo = 1; ale_hi = 1; d = 16'h0044; a = 16'hffff; tick("R8");
    ale_lo = 0; ale_hi = 0; d = 16'h9999; tick("R8");
    sb = 0; tick("R8");
    sb = 1; d = 16'h0000; sa = 0; tick("R8");
    ale_hi = 1; d = 16'h0300; tick("R8");
    ale_hi = 0; sa = 1; tick("R8");
    mux = 0; a = 16'h0044; sa = 0; tick("R8");
    sa = 1;

    // R9 / R10 collision and stall
    cs_n = 2'b00; a = 16'h0050; d = 16'h1111; int_en = 1; int_we = 0; int_addr = 10'h028;
    sb = 0; tick("R9"); tick("R10"); tick("R10");
    int_addr = 10'h029; tick("R9");
    int_addr = 10'h028; tick("R9");
    int_en = 0; tick("R10");
    sb = 1; sa = 0; tick("R10");
    sa = 1; int_en = 1; int_we = 1; int_wdat = 16'h2222; d = 16'h3333; sb = 0; tick("R10");
    int_en = 0; int_we = 0; sb = 1; sa = 0; tick("R10");
    sa = 1; int_en = 1; tick("R9");
    int_en = 0; cs_n = 2'b11; tick("R11");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule